// File: doc/BRIEF.md
# Host-Accessed Byte FIFO with Split Fill Counter

This block is a byte-wide FIFO that a host reaches through a small register window. The host loads an address pointer and then performs a run of reads or writes. After each access the pointer advances by one. The exception is the data-port address, where the pointer holds still, so a host can stream many bytes through one address without reloading it. A length register reports the fill level. A control register selects the depth mode, flushes the buffer, shows a sticky overflow flag, and carries the upper bits of the fill count when the large mode needs more than eight count bits.

A second, internal producer (the datapath side) can push bytes into the same storage through its own strobe. A host pop and an internal push may happen in the same cycle. A host write to the data port takes the single write slot, and an internal push offered in that cycle is discarded.

Top module: `host_fifo_port`

## Requirements
- R1: After reset the fill count is zero, small mode is selected, the overflow flag is clear, and the pointer is 00h. Reads of the length register (04h), the control register (02h) and the data port (05h) all return 00h.
- R2: The address used for an access is `hostAddrIn` when `hostAddrLoad` is high in that cycle, and the stored pointer otherwise. After an access to any address other than 05h, the pointer becomes that address plus one, wrapping from FFh to 00h. After an access to 05h, the pointer equals 05h. A load with no access sets the pointer to `hostAddrIn`.
- R3: A host write to 05h stores one byte and raises the count by one. A host read of 05h returns the oldest stored byte, combinationally during the read cycle, removes it and lowers the count by one. Bytes leave in the order they entered.
- R4: Reading 04h returns count bits 7:0. Reading 02h returns the large-mode bit in bit 7, the overflow flag in bit 5, and count bits 9:8 in bits 1:0. All other bits read 0.
- R5: Capacity is 255 bytes in small mode and 512 bytes in large mode. A push offered while the FIFO is full is dropped and sets the overflow flag. The flag stays set until a flush.
- R6: A read of 05h while the FIFO is empty returns 00h and leaves the count unchanged.
- R7: Writing 02h with bit 6 set flushes the FIFO: the count and the overflow flag are zero on the next cycle. Writing 02h with bit 7 different from the current mode changes the mode and also flushes. Bit 6 always reads 0.
- R8: An internal push and a host pop in the same cycle, on a FIFO that is neither empty nor full, leave the count unchanged. When an internal push and a host write to 05h coincide, only the host byte is stored, and the overflow flag is not set.
- R9: Addresses other than 02h, 04h and 05h read 00h, and writes to them have no effect on the FIFO or the control state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostAddrLoad | input | 1 | Load the address pointer from hostAddrIn |
| hostAddrIn | input | 8 | Address to load |
| hostWr | input | 1 | Host write strobe |
| hostRd | input | 1 | Host read strobe |
| hostWdata | input | 8 | Host write data |
| hostRdata | output | 8 | Read data for the current address (combinational) |
| extPushValid | input | 1 | Internal producer push strobe |
| extPushData | input | 8 | Internal producer byte |

## Verification
A wrong pointer shows up in the very next access: the read lands on the wrong register, or a burst through 05h strays onto the neighbouring addresses. A wrong count or storage pointer shows up in the next length read, or in the first popped byte that breaks arrival order. A fault in the full test or in the overflow flag only shows up at the boundary, so the bench fills both modes to exactly their capacity, pushes once more, and reads the two count registers at once. Collisions between the internal producer and the host are checked by reading the length back in the cycle after the collision.

// File: rtl/host_fifo_pkg.sv
package host_fifo_pkg;
  localparam logic [7:0] ADDR_CTRL = 8'h02;
  localparam logic [7:0] ADDR_LEN  = 8'h04;
  localparam logic [7:0] ADDR_DATA = 8'h05;

  typedef struct packed {
    logic hostPush;
    logic hostPop;
    logic flush;
    logic largeMode;
  } fifoStrobe_t;
endpackage

// File: rtl/host_fifo_ctrl.sv
module host_fifo_ctrl
  import host_fifo_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostAddrLoad,
  input  logic [7:0]       hostAddrIn,
  input  logic             hostWr,
  input  logic             hostRd,
  input  logic             modeBit,
  input  logic             flushBit,
  input  logic [CNT_W-1:0] fillCount,
  input  logic [7:0]       headByte,
  input  logic             overflow,
  output fifoStrobe_t      strobe,
  output logic [7:0]       hostRdata
);
  logic [7:0] ptr;
  logic [7:0] effAddr;
  logic       access;
  logic       largeMode;
  logic       ctrlWrite;
  logic [7:0] hiCount;

  assign effAddr   = hostAddrLoad ? hostAddrIn : ptr;
  assign access    = hostWr | hostRd;
  assign ctrlWrite = hostWr && (effAddr == ADDR_CTRL);
  assign hiCount   = 8'(fillCount >> 8);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= 8'h00;
    end else if (access) begin
      ptr <= (effAddr == ADDR_DATA) ? effAddr : effAddr + 8'd1;
    end else if (hostAddrLoad) begin
      ptr <= hostAddrIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) largeMode <= 1'b0;
    else if (ctrlWrite) largeMode <= modeBit;
  end

  always_comb begin
    strobe.hostPush  = hostWr && (effAddr == ADDR_DATA);
    strobe.hostPop   = hostRd && (effAddr == ADDR_DATA);
    strobe.flush     = ctrlWrite && (flushBit || (modeBit != largeMode));
    strobe.largeMode = largeMode;
  end

  always_comb begin
    unique case (effAddr)
      ADDR_CTRL: hostRdata = {largeMode, 1'b0, overflow, 5'b00000} | (hiCount & 8'h03);
      ADDR_LEN:  hostRdata = fillCount[7:0];
      ADDR_DATA: hostRdata = (fillCount == '0) ? 8'h00 : headByte;
      default:   hostRdata = 8'h00;
    endcase
  end

  assert_ptr_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (access && effAddr == ADDR_DATA) |=> (ptr == ADDR_DATA));
  assert_ptr_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (access && effAddr != ADDR_DATA) |=> (ptr == 8'($past(effAddr) + 8'd1)));
  assert_single_access_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(hostWr && hostRd));
endmodule

// File: rtl/host_fifo_data.sv
module host_fifo_data
  import host_fifo_pkg::*;
#(
  parameter int DEPTH_SMALL = 255,
  parameter int DEPTH_LARGE = 512,
  parameter int CNT_W = $clog2(DEPTH_LARGE + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoStrobe_t      strobe,
  input  logic [7:0]       hostWdata,
  input  logic             extPushValid,
  input  logic [7:0]       extPushData,
  output logic [CNT_W-1:0] fillCount,
  output logic [7:0]       headByte,
  output logic             overflow
);
  localparam int PTR_W = $clog2(DEPTH_LARGE);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH_LARGE - 1);

  logic [7:0]       mem [DEPTH_LARGE];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] limit;
  logic             full, wantPush, doPush, doPop;
  logic [7:0]       pushByte;

  assign limit    = strobe.largeMode ? CNT_W'(DEPTH_LARGE) : CNT_W'(DEPTH_SMALL);
  assign full     = fillCount >= limit;
  assign wantPush = strobe.hostPush | extPushValid;
  assign pushByte = strobe.hostPush ? hostWdata : extPushData;
  assign doPush   = wantPush && !full;
  assign doPop    = strobe.hostPop && (fillCount != '0);
  assign headByte = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush && !strobe.flush) mem[wrPtr] <= pushByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fillCount <= '0;
      overflow  <= 1'b0;
    end else if (strobe.flush) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fillCount <= '0;
      overflow  <= 1'b0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      if (doPush && !doPop)      fillCount <= fillCount + 1'b1;
      else if (doPop && !doPush) fillCount <= fillCount - 1'b1;
      if (wantPush && full) overflow <= 1'b1;
    end
  end

  assert_cap_R5: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= limit);
  assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !strobe.flush) |=> overflow);
  assert_flush_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flush |=> (fillCount == '0 && !overflow));
  assert_empty_pop_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.hostPop && fillCount == '0 && !wantPush && !strobe.flush) |=> (fillCount == '0));
  assert_push_pop_R8: assert property (@(posedge clk) disable iff (!rstN)
    (extPushValid && strobe.hostPop && fillCount != '0 && !full && !strobe.flush)
    |=> $stable(fillCount));
endmodule

// File: rtl/host_fifo_port.sv
module host_fifo_port
  import host_fifo_pkg::*;
#(
  parameter int DEPTH_SMALL = 255,
  parameter int DEPTH_LARGE = 512
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostAddrLoad,
  input  logic [7:0] hostAddrIn,
  input  logic       hostWr,
  input  logic       hostRd,
  input  logic [7:0] hostWdata,
  output logic [7:0] hostRdata,
  input  logic       extPushValid,
  input  logic [7:0] extPushData
);
  localparam int CNT_W = $clog2(DEPTH_LARGE + 1);

  fifoStrobe_t      strobe;
  logic [CNT_W-1:0] fillCount;
  logic [7:0]       headByte;
  logic             overflow;

  host_fifo_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .hostAddrLoad(hostAddrLoad), .hostAddrIn(hostAddrIn),
    .hostWr(hostWr), .hostRd(hostRd),
    .modeBit(hostWdata[7]), .flushBit(hostWdata[6]),
    .fillCount(fillCount), .headByte(headByte), .overflow(overflow),
    .strobe(strobe), .hostRdata(hostRdata)
  );

  host_fifo_data #(.DEPTH_SMALL(DEPTH_SMALL), .DEPTH_LARGE(DEPTH_LARGE), .CNT_W(CNT_W)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .hostWdata(hostWdata),
    .extPushValid(extPushValid), .extPushData(extPushData),
    .fillCount(fillCount), .headByte(headByte), .overflow(overflow)
  );
endmodule

// File: tb/sim_host_fifo_port.sv
`timescale 1ns/1ps
module sim_host_fifo_port;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostAddrLoad = 1'b0, hostWr = 1'b0, hostRd = 1'b0, extPushValid = 1'b0;
  logic [7:0] hostAddrIn = '0, hostWdata = '0, extPushData = '0;
  logic [7:0] hostRdata;
  int runCount = 0, failCount = 0;
  logic [7:0] got;

  always #4 clk = ~clk;

  host_fifo_port u0 (
    .clk(clk), .rstN(rstN), .hostAddrLoad(hostAddrLoad), .hostAddrIn(hostAddrIn),
    .hostWr(hostWr), .hostRd(hostRd), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .extPushValid(extPushValid), .extPushData(extPushData)
  );

  // {load, wr, rd, addr, wdata, expected read}
  localparam int NV = 21;
  localparam logic [26:0] VEC [NV] = '{
    {1'b1,1'b1,1'b0,8'h05,8'hAA,8'h00},
    {1'b0,1'b1,1'b0,8'h00,8'hBB,8'h00},
    {1'b0,1'b1,1'b0,8'h00,8'hCC,8'h00},
    {1'b1,1'b0,1'b1,8'h04,8'h00,8'h03},
    {1'b0,1'b0,1'b1,8'h00,8'h00,8'hAA},
    {1'b0,1'b0,1'b1,8'h00,8'h00,8'hBB},
    {1'b1,1'b0,1'b1,8'h04,8'h00,8'h01},
    {1'b0,1'b0,1'b1,8'h00,8'h00,8'hCC},
    {1'b0,1'b0,1'b1,8'h00,8'h00,8'h00},
    {1'b1,1'b0,1'b1,8'h04,8'h00,8'h00},
    {1'b0,1'b1,1'b0,8'h00,8'h11,8'h00},
    {1'b1,1'b1,1'b0,8'h07,8'h5A,8'h00},
    {1'b1,1'b0,1'b1,8'h07,8'h00,8'h00},
    {1'b1,1'b0,1'b1,8'hFF,8'h00,8'h00},
    {1'b0,1'b0,1'b1,8'h00,8'h00,8'h00},
    {1'b0,1'b0,1'b1,8'h00,8'h00,8'h00},
    {1'b0,1'b0,1'b1,8'h00,8'h00,8'h00},
    {1'b0,1'b0,1'b1,8'h00,8'h00,8'h00},
    {1'b0,1'b0,1'b1,8'h00,8'h00,8'h01},
    {1'b0,1'b0,1'b1,8'h00,8'h00,8'h11},
    {1'b0,1'b0,1'b1,8'h00,8'h00,8'h00}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    runCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  // One host cycle; read data sampled at the falling edge, committed at the next rising edge.
  task automatic hop(input logic ld, input logic [7:0] a, input logic w, input logic r,
                     input logic [7:0] wd, input logic ev, input logic [7:0] ed,
                     output logic [7:0] rd);
    @(posedge clk); #1;
    hostAddrLoad = ld; hostAddrIn = a; hostWr = w; hostRd = r; hostWdata = wd;
    extPushValid = ev; extPushData = ed;
    @(negedge clk);
    rd = hostRdata;
  endtask

  task automatic idle();
    @(posedge clk); #1;
    hostAddrLoad = 0; hostWr = 0; hostRd = 0; extPushValid = 0;
  endtask

  task automatic rdAt(input logic [7:0] a, output logic [7:0] rd);
    hop(1, a, 0, 1, 8'h00, 0, 8'h00, rd);
  endtask

  task automatic wrAt(input logic [7:0] a, input logic [7:0] d);
    logic [7:0] unused;
    hop(1, a, 1, 0, d, 0, 8'h00, unused);
  endtask

  initial begin
    #(8 * 200000);
    failCount++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", runCount, failCount);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    rdAt(8'h04, got); check("R1 length", got, 8'h00);
    rdAt(8'h02, got); check("R1 control", got, 8'h00);
    rdAt(8'h05, got); check("R1 data", got, 8'h00);
    // Vector walk: R2 pointer, R3 order, R4 length, R6 empty, R9 unmapped
    for (int i = 0; i < NV; i++) begin
      hop(VEC[i][26], VEC[i][23:16], VEC[i][25], VEC[i][24], VEC[i][15:8], 0, 8'h00, got);
      if (VEC[i][24]) check($sformatf("R2 R3 R4 R6 R9 vector %0d", i), got, VEC[i][7:0]);
    end
    idle();
    // R5 small capacity and overflow
    for (int i = 0; i < 255; i++) wrAt(8'h05, 8'(i));
    wrAt(8'h05, 8'hEE);
    rdAt(8'h04, got); check("R5 small full length", got, 8'hFF);
    rdAt(8'h02, got); check("R5 overflow flag", got, 8'h20);
    rdAt(8'h05, got); check("R5 first byte kept", got, 8'h00);
    // R7 flush
    wrAt(8'h02, 8'h40);
    rdAt(8'h02, got); check("R7 flush control", got, 8'h00);
    rdAt(8'h04, got); check("R7 flush length", got, 8'h00);
    // R5 large capacity, R4 split count
    wrAt(8'h02, 8'h80);
    for (int i = 0; i < 512; i++) wrAt(8'h05, 8'(i));
    rdAt(8'h04, got); check("R4 large low count", got, 8'h00);
    rdAt(8'h02, got); check("R4 large high count", got, 8'h82);
    wrAt(8'h05, 8'hEE);
    rdAt(8'h02, got); check("R5 large overflow", got, 8'hA2);
    rdAt(8'h05, got); check("R3 large pop0", got, 8'h00);
    rdAt(8'h05, got); check("R3 large pop1", got, 8'h01);
    // R8 internal push with host pop
    hop(1, 8'h05, 0, 1, 8'h00, 1, 8'h99, got);
    check("R8 pop during push", got, 8'h02);
    rdAt(8'h04, got); check("R8 count held low", got, 8'hFE);
    rdAt(8'h02, got); check("R8 count held high", got, 8'hA1);
    // R8 host write wins over internal push
    wrAt(8'h02, 8'hC0);
    hop(1, 8'h00, 0, 0, 8'h00, 1, 8'h77, got);
    hop(1, 8'h05, 1, 0, 8'h33, 1, 8'h99, got);
    idle();
    rdAt(8'h04, got); check("R8 collision count", got, 8'h02);
    rdAt(8'h02, got); check("R8 no overflow", got, 8'h80);
    rdAt(8'h05, got); check("R8 internal byte", got, 8'h77);
    rdAt(8'h05, got); check("R8 host byte", got, 8'h33);
    rdAt(8'h05, got); check("R6 empty again", got, 8'h00);
    rdAt(8'h04, got); check("R6 count stays zero", got, 8'h00);
    // R7 mode change flushes
    wrAt(8'h05, 8'h42);
    wrAt(8'h02, 8'h00);
    rdAt(8'h04, got); check("R7 mode change length", got, 8'h00);
    rdAt(8'h02, got); check("R7 mode change control", got, 8'h00);
    idle();
    $display("  [TB] %0d tests run, %0d failed", runCount, failCount);
    $finish;
  end
endmodule